// File: doc/BRIEF.md
# SDRAM Mode-Set and Refresh Sequencer

This block handles bring-up and upkeep for an SDRAM controller. When asked to start, it closes all banks with a precharge-all command. It then issues a mode-set command. During the mode-set cycle the multiplexed address lines carry a mode word built from the configuration inputs: CAS latency, burst type, and a burst-length code chosen from the data port width. After a short recovery, the sequencer sits idle and issues auto (CBR) refresh commands at an interval set by a programmable timer.

The block also offers a simple access handshake. A requester holds its request while the ready output is high. The sequencer then opens the requested row with an activate command and keeps the bus for a fixed number of burst cycles. A refresh that falls due during such an access is recorded and held back until the access has ended. While it waits, it takes priority over any new access request.

Top module: `sdram_init_refresh_seq`

## Requirements
- R1: While reset is held and after it is released, the command lines {csN,rasN,casN,weN} read 0111 (NOP), memAddr is zero and accReady is low until initialization completes.
- R2: A start request accepted while uninitialized produces a precharge-all (0010, memAddr bit 10 high, other bits zero) in the next cycle, followed at once by a mode-set (0000).
- R3: During the mode-set cycle, memAddr[6:4] carries the CAS latency code, memAddr[3] carries the burst type and memAddr[2:0] carries the burst-length code. All other address bits are zero.
- R4: The burst-length code is 010 when portSize is 01 (16-bit) or 11 (64-bit), and 011 when portSize is 00 (8-bit) or 10 (32-bit).
- R5: A start request is ignored unless casLatCfg is 001, 010 or 011. The outputs stay at NOP and not-ready.
- R6: Mode-set is followed by exactly two NOP cycles and then one idle NOP cycle, in which accReady may rise, before any other command.
- R7: The refresh timer loads refInterval-1 when mode-set is issued and counts down. It expires every refInterval cycles, and each expiry sets a pending flag. An idle cycle that sees the flag is followed by an auto refresh (0001) with memAddr zero.
- R8: Each auto refresh is followed by six NOP cycles and then an idle cycle.
- R9: accReady is high only in an idle cycle with no refresh pending. A request seen in such a cycle yields an activate (0011) carrying the sampled accRow in the next cycle, followed by four NOP burst cycles and then an idle cycle.
- R10: No refresh is issued between an activate and the end of its burst cycles. When a refresh is pending, an access request in the idle cycle is refused and the refresh goes first.
- R11: The pending flag stays set until an auto refresh is issued. Expiries that occur while it is set merge into a single refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Request to run precharge-all and mode-set |
| casLatCfg | input | 3 | CAS latency code (1 to 3 are legal) |
| burstTypeCfg | input | 1 | Burst type bit of the mode word |
| portSize | input | 2 | Data port width: 00=8, 01=16, 10=32, 11=64 bits |
| refInterval | input | 16 | Refresh period in clocks (at least 1) |
| accReq | input | 1 | Access request |
| accRow | input | 12 | Row address for the requested access |
| accReady | output | 1 | Access request will be accepted this cycle |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| memAddr | output | 12 | Multiplexed address: mode word, row or precharge flag |

## Verification
The interesting collision is a refresh expiry that falls during an access burst, or in the same idle cycle as an access request. The bench provokes it by holding access requests high or toggling them in short patterns, combined with refresh intervals of 3, 10 and 17 clocks. Expiries therefore land inside activate bursts, inside refresh recovery and on idle cycles. Each cycle is judged against a queue-based model of the expected command stream. A monitor separately counts any refresh found inside an activate burst, and checks that a fast timer yields merged rather than lost or doubled refreshes.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;
  // {csN, rasN, casN, weN}
  localparam logic [3:0] CMD_MRS = 4'b0000;
  localparam logic [3:0] CMD_REF = 4'b0001;
  localparam logic [3:0] CMD_PRE = 4'b0010;
  localparam logic [3:0] CMD_ACT = 4'b0011;
  localparam logic [3:0] CMD_NOP = 4'b0111;

  typedef enum logic [1:0] {
    ADDR_ZERO,
    ADDR_PRE,
    ADDR_MODE,
    ADDR_ROW
  } addrSel_e;

  typedef struct packed {
    logic     loadMode;
    logic     loadTimer;
    logic     clrPend;
    logic     latchRow;
    addrSel_e addrSel;
  } seqStrobe_t;
endpackage

// File: rtl/sdr_seq_dp.sv
module sdr_seq_dp
  import sdr_seq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int TMR_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        stb,
  input  logic [2:0]        casLatCfg,
  input  logic              burstTypeCfg,
  input  logic [1:0]        portSize,
  input  logic [TMR_W-1:0]  refInterval,
  input  logic [ADDR_W-1:0] accRow,
  output logic              clLegal,
  output logic              refPending,
  output logic [ADDR_W-1:0] memAddr
);
  localparam int PRE_BIT = 10;

  logic [ADDR_W-1:0] modeWord, modeNext, rowReg;
  logic [TMR_W-1:0]  tmrCnt, tmrReload;
  logic              tmrRun, tmrExpire;
  logic [2:0]        blCode;

  assign clLegal = (casLatCfg != 3'b000) && !casLatCfg[2];

  always_comb begin
    case (portSize)
      2'b01, 2'b11: blCode = 3'b010;
      default:      blCode = 3'b011;
    endcase
    modeNext      = '0;
    modeNext[2:0] = blCode;
    modeNext[3]   = burstTypeCfg;
    modeNext[6:4] = casLatCfg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeWord <= '0;
      rowReg   <= '0;
    end else begin
      if (stb.loadMode) modeWord <= modeNext;
      if (stb.latchRow) rowReg   <= accRow;
    end
  end

  assign tmrReload = refInterval - TMR_W'(1);
  assign tmrExpire = tmrRun && !stb.loadTimer && (tmrCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmrCnt     <= '0;
      tmrRun     <= 1'b0;
      refPending <= 1'b0;
    end else begin
      if (stb.loadTimer) begin
        tmrCnt <= tmrReload;
        tmrRun <= 1'b1;
      end else if (tmrRun) begin
        tmrCnt <= (tmrCnt == '0) ? tmrReload : tmrCnt - TMR_W'(1);
      end
      if (tmrExpire)        refPending <= 1'b1;
      else if (stb.clrPend) refPending <= 1'b0;
    end
  end

  always_comb begin
    memAddr = '0;
    case (stb.addrSel)
      ADDR_PRE:  memAddr[PRE_BIT] = 1'b1;
      ADDR_MODE: memAddr = modeWord;
      ADDR_ROW:  memAddr = rowReg;
      default:   memAddr = '0;
    endcase
  end

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    refPending && !stb.clrPend |=> refPending);  // R11
  AST_MODE_CL_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (stb.addrSel == ADDR_MODE) |-> (memAddr[6:4] != 3'b000 && !memAddr[6]));  // R5
  AST_MODE_BL_CODE: assert property (@(posedge clk) disable iff (!rstN)
    (stb.addrSel == ADDR_MODE) |-> (memAddr[2:1] == 2'b01));  // R4
endmodule

// File: rtl/sdr_seq_ctrl.sv
module sdr_seq_ctrl
  import sdr_seq_pkg::*;
#(
  parameter int MRS_REC = 2,
  parameter int REF_REC = 6,
  parameter int ACC_CYC = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       accReq,
  input  logic       clLegal,
  input  logic       refPending,
  output seqStrobe_t stb,
  output logic [3:0] cmd,
  output logic       accReady
);
  localparam int WAIT_A   = (MRS_REC > REF_REC) ? MRS_REC : REF_REC;
  localparam int WAIT_MAX = (WAIT_A > ACC_CYC) ? WAIT_A : ACC_CYC;
  localparam int CW       = $clog2(WAIT_MAX + 1);

  typedef enum logic [3:0] {
    ST_UNINIT, ST_PRECH, ST_MRS, ST_MREC, ST_IDLE,
    ST_ACT, ST_ACC, ST_REF, ST_RREC
  } seqState_e;

  seqState_e       state, nxt;
  logic [CW-1:0]   waitCnt, waitVal;
  logic            loadWait;

  always_comb begin
    nxt         = state;
    stb         = '0;
    stb.addrSel = ADDR_ZERO;
    cmd         = CMD_NOP;
    loadWait    = 1'b0;
    waitVal     = '0;
    case (state)
      ST_UNINIT: if (startReq && clLegal) begin
        nxt          = ST_PRECH;
        stb.loadMode = 1'b1;
      end
      ST_PRECH: begin
        cmd         = CMD_PRE;
        stb.addrSel = ADDR_PRE;
        nxt         = ST_MRS;
      end
      ST_MRS: begin
        cmd           = CMD_MRS;
        stb.addrSel   = ADDR_MODE;
        stb.loadTimer = 1'b1;
        loadWait      = 1'b1;
        waitVal       = CW'(MRS_REC - 1);
        nxt           = ST_MREC;
      end
      ST_IDLE: begin
        if (refPending) nxt = ST_REF;
        else if (accReq) begin
          nxt          = ST_ACT;
          stb.latchRow = 1'b1;
        end
      end
      ST_ACT: begin
        cmd         = CMD_ACT;
        stb.addrSel = ADDR_ROW;
        loadWait    = 1'b1;
        waitVal     = CW'(ACC_CYC - 1);
        nxt         = ST_ACC;
      end
      ST_REF: begin
        cmd         = CMD_REF;
        stb.clrPend = 1'b1;
        loadWait    = 1'b1;
        waitVal     = CW'(REF_REC - 1);
        nxt         = ST_RREC;
      end
      ST_MREC, ST_ACC, ST_RREC: if (waitCnt == '0) nxt = ST_IDLE;
      default: nxt = ST_UNINIT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_UNINIT;
      waitCnt <= '0;
    end else begin
      state <= nxt;
      if (loadWait)            waitCnt <= waitVal;
      else if (waitCnt != '0)  waitCnt <= waitCnt - CW'(1);
    end
  end

  assign accReady = (state == ST_IDLE) && !refPending;

  AST_MRS_AFTER_PRE: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == CMD_MRS) |-> ($past(cmd) == CMD_PRE));  // R2
  AST_MRS_REC_1: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == CMD_MRS) |=> (cmd == CMD_NOP));  // R6
  AST_MRS_REC_2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(cmd, 2) == CMD_MRS) |-> (cmd == CMD_NOP && !accReady));  // R6
  AST_REF_REC: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == CMD_REF) |=> (cmd == CMD_NOP));  // R8
  AST_ACT_GRANTED: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == CMD_ACT) |-> $past(accReady && accReq));  // R9
  AST_ACT_NO_PEND: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == CMD_ACT) |-> !$past(refPending));  // R10
endmodule

// File: rtl/sdram_init_refresh_seq.sv
module sdram_init_refresh_seq
  import sdr_seq_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int TMR_W   = 16,
  parameter int MRS_REC = 2,
  parameter int REF_REC = 6,
  parameter int ACC_CYC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [2:0]        casLatCfg,
  input  logic              burstTypeCfg,
  input  logic [1:0]        portSize,
  input  logic [TMR_W-1:0]  refInterval,
  input  logic              accReq,
  input  logic [ADDR_W-1:0] accRow,
  output logic              accReady,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [ADDR_W-1:0] memAddr
);
  seqStrobe_t stb;
  logic       clLegal, refPending;
  logic [3:0] cmd;

  sdr_seq_ctrl #(.MRS_REC(MRS_REC), .REF_REC(REF_REC), .ACC_CYC(ACC_CYC)) ctrl_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .accReq(accReq),
    .clLegal(clLegal), .refPending(refPending), .stb(stb), .cmd(cmd),
    .accReady(accReady)
  );

  sdr_seq_dp #(.ADDR_W(ADDR_W), .TMR_W(TMR_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .casLatCfg(casLatCfg),
    .burstTypeCfg(burstTypeCfg), .portSize(portSize),
    .refInterval(refInterval), .accRow(accRow), .clLegal(clLegal),
    .refPending(refPending), .memAddr(memAddr)
  );

  assign {csN, rasN, casN, weN} = cmd;
endmodule

// File: tb/sdram_init_refresh_seq_tb.sv
module sdram_init_refresh_seq_tb_top;
  import sdr_seq_pkg::*;
  localparam int AW = 12, TW = 16, ACC_N = 4, MREC_N = 2, RREC_N = 6;

  logic clk = 1'b0, rstN = 1'b0, startReq = 1'b0, burstTypeCfg = 1'b0, accReq = 1'b0;
  logic [2:0] casLatCfg = 3'd0;
  logic [1:0] portSize = 2'd0;
  logic [TW-1:0] refInterval = 16'd40;
  logic [AW-1:0] accRow = '0, memAddr;
  logic accReady, csN, rasN, casN, weN;

  int checks = 0, errors = 0;
  int refTotal = 0, refInAcc = 0, accLeft = 0;

  always #10 clk = ~clk;

  sdram_init_refresh_seq dut_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .casLatCfg(casLatCfg),
    .burstTypeCfg(burstTypeCfg), .portSize(portSize), .refInterval(refInterval),
    .accReq(accReq), .accRow(accRow), .accReady(accReady), .csN(csN),
    .rasN(rasN), .casN(casN), .weN(weN), .memAddr(memAddr)
  );

  // ---------------- behavioural reference model ----------------
  logic [3:0]    qCmd[$];
  logic [AW-1:0] qAddr[$];
  string         qTag[$];
  logic [3:0]    mCmd;
  logic [AW-1:0] mAddr;
  string         mTag;
  bit            mIdle, mInit, mRun, mPend, live;
  int            mCnt;

  task automatic push(input logic [3:0] c, input logic [AW-1:0] a, input string t);
    qCmd.push_back(c); qAddr.push_back(a); qTag.push_back(t);
  endtask

  task automatic setIdle(input string t);
    mCmd = CMD_NOP; mAddr = '0; mIdle = 1'b1; mTag = t;
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      qCmd.delete(); qAddr.delete(); qTag.delete();
      setIdle("R1"); mInit = 0; mRun = 0; mPend = 0; mCnt = 0; live = 0;
    end else begin
      bit oldPend, setP;
      logic [AW-1:0] w;
      live = 1; oldPend = mPend; setP = 0;
      if (mCmd == CMD_MRS) begin mRun = 1; mCnt = int'(refInterval) - 1; end
      else if (mRun) begin
        if (mCnt == 0) begin setP = 1; mCnt = int'(refInterval) - 1; end
        else mCnt--;
      end
      if (setP) mPend = 1;
      else if (mCmd == CMD_REF) mPend = 0;
      if (qCmd.size() > 0) begin
        mCmd = qCmd.pop_front(); mAddr = qAddr.pop_front(); mTag = qTag.pop_front();
        mIdle = 0;
      end else if (!mIdle) setIdle("R6");
      else if (!mInit) begin
        if (startReq && casLatCfg >= 1 && casLatCfg <= 3) begin
          w = '0; w[6:4] = casLatCfg; w[3] = burstTypeCfg;
          w[2:0] = (portSize == 2'b01 || portSize == 2'b11) ? 3'b010 : 3'b011;
          mCmd = CMD_PRE; mAddr = 12'h400; mTag = "R2"; mIdle = 0; mInit = 1;
          push(CMD_MRS, w, "R3 R4");
          for (int k = 0; k < MREC_N; k++) push(CMD_NOP, '0, "R6");
        end else setIdle("R5");
      end else if (oldPend) begin
        mCmd = CMD_REF; mAddr = '0; mTag = "R7"; mIdle = 0;
        for (int k = 0; k < RREC_N; k++) push(CMD_NOP, '0, "R8");
      end else if (accReq) begin
        mCmd = CMD_ACT; mAddr = accRow; mTag = "R9"; mIdle = 0;
        for (int k = 0; k < ACC_N; k++) push(CMD_NOP, '0, "R10");
      end else setIdle("R9");
    end
  end

  // ---------------- per-cycle comparison and monitors ----------------
  always @(negedge clk) begin
    if (live) begin
      logic expRdy;
      expRdy = mIdle && mInit && !mPend;
      checks++;
      if ({csN, rasN, casN, weN} !== mCmd || memAddr !== mAddr || accReady !== expRdy) begin
        errors++;
        $display("FAIL %s (R9 ready) cmd=%b exp=%b addr=%h exp=%h rdy=%b exp=%b at %0t",
                 mTag, {csN, rasN, casN, weN}, mCmd, memAddr, mAddr, accReady, expRdy, $time);
      end
      if ({csN, rasN, casN, weN} == CMD_ACT) accLeft = ACC_N;
      else begin
        if ({csN, rasN, casN, weN} == CMD_REF) begin
          refTotal++;
          if (accLeft > 0) refInAcc++;
        end
        if (accLeft > 0) accLeft--;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0; startReq = 1'b0; accReq = 1'b0;
    cyc(2); rstN = 1'b1;
  endtask

  task automatic startInit(input logic [2:0] cl, input logic [1:0] ps, input logic bt,
                           input logic [TW-1:0] iv);
    casLatCfg = cl; portSize = ps; burstTypeCfg = bt; refInterval = iv;
    startReq = 1'b1; cyc(1); startReq = 1'b0;
  endtask

  initial begin
    int base;
    // R1: reset state
    cyc(3);
    check({csN, rasN, casN, weN} == CMD_NOP, "R1 cmd", {csN, rasN, casN, weN}, CMD_NOP);
    check(memAddr == '0, "R1 addr", memAddr, 0);
    check(accReady == 1'b0, "R1 ready", accReady, 0);
    rstN = 1'b1;
    cyc(3);
    // R5: illegal latencies ignored
    casLatCfg = 3'd0; startReq = 1'b1; cyc(4);
    casLatCfg = 3'd5; cyc(4);
    casLatCfg = 3'd7; cyc(3); startReq = 1'b0; cyc(2);
    check({csN, rasN, casN, weN} == CMD_NOP && !accReady, "R5 still uninit",
          {csN, rasN, casN, weN}, CMD_NOP);
    // 8-bit port, latency 2, moderate interval, mixed requests
    startInit(3'd2, 2'b00, 1'b0, 16'd40);
    for (int i = 0; i < 300; i++) begin
      accReq = (i % 7) < 3; accRow = AW'(i * 37); cyc(1);
    end
    accReq = 1'b0;
    // 16-bit port, latency 3, fast timer with requests held high: merging
    doReset();
    startInit(3'd3, 2'b01, 1'b1, 16'd3);
    base = refTotal;
    for (int i = 0; i < 120; i++) begin
      accReq = 1'b1; accRow = AW'(12'hA00 + i); cyc(1);
    end
    accReq = 1'b0;
    check(refTotal - base > 0 && refTotal - base <= 16, "R11 merged refresh count",
          refTotal - base, 15);
    // 32-bit port, latency 1
    doReset();
    startInit(3'd1, 2'b10, 1'b0, 16'd10);
    for (int i = 0; i < 150; i++) begin
      accReq = (i % 3) != 0; accRow = AW'(i * 91); cyc(1);
    end
    accReq = 1'b0;
    // 64-bit port, latency 2
    doReset();
    startInit(3'd2, 2'b11, 1'b1, 16'd17);
    for (int i = 0; i < 150; i++) begin
      accReq = (i % 4) >= 2; accRow = AW'(12'hFFF - i); cyc(1);
    end
    accReq = 1'b0;
    cyc(10);
    check(refInAcc == 0, "R10 refresh inside burst", refInAcc, 0);
    check(refTotal > 20, "R7 refreshes issued", refTotal, 21);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog expired actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule